// File: doc/BRIEF.md
# Run-Mode Clock Source Switch Controller

This block picks the system clock of a small processor from two sources: an internal RC oscillator that never stops, and a primary oscillator whose output can optionally pass through a PLL. A 2-bit source-select register, written from the internal clock domain, sets the wanted source. Moving to the internal oscillator is quick. The primary-stable flag drops on the same edge as the write, and the primary oscillator is switched off once the clock multiplexer has let go of it.

Moving back to the primary source is deferred. The core keeps running from the internal clock while the primary oscillator is enabled. A start-up timer counts primary periods, and if the PLL is in use a further lock interval is counted on the internal clock. Only after both have elapsed does a glitch-free multiplexer hand the system clock over. The primary-stable flag rises once that handover is complete.

The internal oscillator enable also stays on whenever the watchdog or the clock monitor needs that clock. All control state lives in the internal clock domain, under a synchronous active-high reset.

Top module: `clksw_ctl`

## Requirements
- R1: After reset, `sel_q` is 2'b11, `idle_q` is 0, `pri_en`, `pll_en` and `pri_stable` are 0, and `sys_clk` runs at the internal clock period.
- R2: A cycle with `cfg_wr` high loads `cfg_sel` into `sel_q` and `cfg_idle` into `idle_q` on the next internal clock edge. The value 2'b11 selects the internal oscillator. The values 2'b00, 2'b01 and 2'b10 all select primary run.
- R3: On the edge that loads a primary selection while the block is on the internal oscillator, `pri_en` rises. `pll_en` rises with it if `pll_use` is high in that cycle. `sys_clk` keeps the internal period while `pri_stable` is low.
- R4: `pri_stable` stays low for at least `OST_CYCLES` primary periods after `pri_en` rises.
- R5: If the PLL was requested, `pri_stable` additionally waits `PLL_LOCK_CYCLES` internal clock cycles after the start-up count.
- R6: Once `pri_stable` is high, `sys_clk` runs at the primary period, or at the PLL period if the PLL was requested, and `pri_stable` rises within a bounded number of cycles after the waits of R4 and R5.
- R7: On the edge that loads 2'b11, `pri_stable` goes low. `pri_en` and `pll_en` fall within 12 internal cycles, after which `sys_clk` runs at the internal period.
- R8: Loading 2'b11 while a start-up or lock wait is pending abandons it: `pri_stable` never rises and the primary enable drops.
- R9: The block never changes `sel_q` or `idle_q` on its own; they change only on `cfg_wr`.
- R10: `int_osc_en` is high whenever `pri_stable` is low or `wdt_en` or `fscm_en` is high, and low otherwise.
- R11: No high or low phase of `sys_clk` is shorter than the shorter half-period of the two sources it switches between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal RC oscillator clock, always running |
| clk_pri | input | 1 | Primary oscillator clock |
| clk_pll | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the select register |
| cfg_sel | input | 2 | Source-select value to load |
| cfg_idle | input | 1 | Idle-enable value to load |
| pll_use | input | 1 | Route the primary source through the PLL on the next start-up |
| wdt_en | input | 1 | Watchdog needs the internal oscillator |
| fscm_en | input | 1 | Clock monitor needs the internal oscillator |
| sel_q | output | 2 | Current source-select register |
| idle_q | output | 1 | Current idle-enable bit |
| pri_en | output | 1 | Primary oscillator enable |
| pll_en | output | 1 | PLL enable |
| pri_stable | output | 1 | System clock is running from the primary source |
| int_osc_en | output | 1 | Internal oscillator keep-alive |
| sys_clk | output | 1 | Glitch-free system clock |

## Verification
The bench goes after the start-up window. A design that counts too few primary periods, or skips the PLL lock wait, raises the stable flag early. One that never completes the handover leaves the flag low, or leaves the system clock at the internal period.

It also aborts a start-up in the middle of the oscillator count and again in the middle of the PLL lock. A design that kept going would raise the stable flag, or leave the primary enable on, after the internal source was chosen. Every edge of the system clock is timed, so a runt pulse from a badly ordered handover shows up. Between writes, the select input carries stray values, so a register that latched without the strobe would be seen.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
    typedef enum logic [2:0] {
        ST_INT   = 3'd0,
        ST_OST   = 3'd1,
        ST_LOCK  = 3'd2,
        ST_SWAP  = 3'd3,
        ST_PRI   = 3'd4,
        ST_DRAIN = 3'd5
    } sw_state_e;

    localparam logic [1:0] SEL_INTOSC = 2'b11;
endpackage

// File: rtl/clksw_sync2.sv
`timescale 1ns/1ps
module clksw_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s1_d, s2_q, s2_d;

    always_comb begin
        s1_d = d;
        s2_d = s1_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/clksw_ost.sv
`timescale 1ns/1ps
module clksw_ost #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk_pri,
    input  logic rst,
    input  logic run_req,
    output logic done
);
    localparam int CW = $clog2(OST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          done;
    } ost_t;

    ost_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = run_req;
        r_d.s2 = r_q.s1;
        if (!r_q.s2) begin
            r_d.cnt  = '0;
            r_d.done = 1'b0;
        end else if (!r_q.done) begin
            if (r_q.cnt == LAST) r_d.done = 1'b1;
            else                 r_d.cnt  = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_pri) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign done = r_q.done;

    p_cnt_bound_r4: assert property (@(posedge clk_pri) disable iff (rst)
        r_q.cnt <= LAST);
endmodule

// File: rtl/clksw_gmux.sv
`timescale 1ns/1ps
module clksw_gmux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel_b,
    output logic gate_a,
    output logic gate_b,
    output logic clk_out
);
    logic a1_q, b1_q;

    always_ff @(posedge clk_a) begin
        if (rst) a1_q <= 1'b1;
        else     a1_q <= ~sel_b & ~gate_b;
    end

    always_ff @(negedge clk_a) begin
        if (rst) gate_a <= 1'b1;
        else     gate_a <= a1_q;
    end

    always_ff @(posedge clk_b) begin
        if (rst) b1_q <= 1'b0;
        else     b1_q <= sel_b & ~gate_a;
    end

    always_ff @(negedge clk_b) begin
        if (rst) gate_b <= 1'b0;
        else     gate_b <= b1_q;
    end

    assign clk_out = (clk_a & gate_a) | (clk_b & gate_b);

    p_gates_exclusive_r11: assert property (@(posedge clk_a) disable iff (rst)
        $onehot0({gate_a, gate_b}));
endmodule

// File: rtl/clksw_fsm.sv
`timescale 1ns/1ps
module clksw_fsm
    import clksw_pkg::*;
#(
    parameter int LOCK_CYCLES = 16000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    input  logic       cfg_idle,
    input  logic       pll_use,
    input  logic       ost_done_s,
    input  logic       main_on_s,
    input  logic       gate_int,
    output logic [1:0] sel_q,
    output logic       idle_q,
    output logic       pri_en,
    output logic       pll_en,
    output logic       pll_sel,
    output logic       pri_stable,
    output logic       want_main
);
    localparam int LCW = $clog2(LOCK_CYCLES + 1);
    localparam logic [LCW-1:0] LOCK_LAST = LCW'(LOCK_CYCLES - 1);

    typedef struct packed {
        sw_state_e      state;
        logic [1:0]     sel;
        logic           idle;
        logic           pri_en;
        logic           pll_en;
        logic           pll_sel;
        logic           stable;
        logic           want;
        logic [LCW-1:0] lock_cnt;
    } fsm_t;

    fsm_t r_q, r_d;
    logic [1:0] sel_nx;
    logic       go_int;

    always_comb begin
        r_d     = r_q;
        sel_nx  = cfg_wr ? cfg_sel : r_q.sel;
        go_int  = (sel_nx == SEL_INTOSC);
        r_d.sel = sel_nx;
        if (cfg_wr) r_d.idle = cfg_idle;

        unique case (r_q.state)
            ST_INT: begin
                if (!go_int && !ost_done_s) begin
                    r_d.state   = ST_OST;
                    r_d.pri_en  = 1'b1;
                    r_d.pll_sel = pll_use;
                    r_d.pll_en  = pll_use;
                end
            end
            ST_OST, ST_LOCK: begin
                if (go_int) begin
                    r_d.state  = ST_INT;
                    r_d.pri_en = 1'b0;
                    r_d.pll_en = 1'b0;
                end else if (r_q.state == ST_OST) begin
                    if (ost_done_s) begin
                        if (r_q.pll_sel) begin
                            r_d.state    = ST_LOCK;
                            r_d.lock_cnt = '0;
                        end else begin
                            r_d.state = ST_SWAP;
                            r_d.want  = 1'b1;
                        end
                    end
                end else if (r_q.lock_cnt == LOCK_LAST) begin
                    r_d.state = ST_SWAP;
                    r_d.want  = 1'b1;
                end else begin
                    r_d.lock_cnt = r_q.lock_cnt + 1'b1;
                end
            end
            ST_SWAP: begin
                if (go_int) begin
                    r_d.state = ST_DRAIN;
                    r_d.want  = 1'b0;
                end else if (main_on_s && !gate_int) begin
                    r_d.state  = ST_PRI;
                    r_d.stable = 1'b1;
                end
            end
            ST_PRI: begin
                if (go_int) begin
                    r_d.state  = ST_DRAIN;
                    r_d.want   = 1'b0;
                    r_d.stable = 1'b0;
                end
            end
            ST_DRAIN: begin
                if (!main_on_s && gate_int) begin
                    r_d.state  = ST_INT;
                    r_d.pri_en = 1'b0;
                    r_d.pll_en = 1'b0;
                end
            end
            default: r_d.state = ST_INT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= ST_INT;
            r_q.sel   <= SEL_INTOSC;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_q      = r_q.sel;
    assign idle_q     = r_q.idle;
    assign pri_en     = r_q.pri_en;
    assign pll_en     = r_q.pll_en;
    assign pll_sel    = r_q.pll_sel;
    assign pri_stable = r_q.stable;
    assign want_main  = r_q.want;

    p_stable_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        pri_stable |-> (pri_en && want_main));
    p_stable_after_ost_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pri_stable) |-> ost_done_s);
    p_int_clears_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_sel == SEL_INTOSC) |=> !pri_stable);
    p_sel_held_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> ($stable(sel_q) && $stable(idle_q)));
endmodule

// File: rtl/clksw_ctl.sv
`timescale 1ns/1ps
module clksw_ctl #(
    parameter int OST_CYCLES      = 1024,
    parameter int PLL_LOCK_CYCLES = 16000
) (
    input  logic       clk_int,
    input  logic       clk_pri,
    input  logic       clk_pll,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    input  logic       cfg_idle,
    input  logic       pll_use,
    input  logic       wdt_en,
    input  logic       fscm_en,
    output logic [1:0] sel_q,
    output logic       idle_q,
    output logic       pri_en,
    output logic       pll_en,
    output logic       pri_stable,
    output logic       int_osc_en,
    output logic       sys_clk
);
    logic ost_done, ost_done_s, main_on_s;
    logic gate_int, gate_main, want_main, pll_sel, clk_main;

    clksw_fsm #(.LOCK_CYCLES(PLL_LOCK_CYCLES)) u_fsm (
        .clk        (clk_int),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_idle   (cfg_idle),
        .pll_use    (pll_use),
        .ost_done_s (ost_done_s),
        .main_on_s  (main_on_s),
        .gate_int   (gate_int),
        .sel_q      (sel_q),
        .idle_q     (idle_q),
        .pri_en     (pri_en),
        .pll_en     (pll_en),
        .pll_sel    (pll_sel),
        .pri_stable (pri_stable),
        .want_main  (want_main)
    );

    clksw_ost #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .clk_pri (clk_pri),
        .rst     (rst),
        .run_req (pri_en),
        .done    (ost_done)
    );

    clksw_sync2 #(.W(2)) u_sync (
        .clk (clk_int),
        .rst (rst),
        .d   ({ost_done, gate_main}),
        .q   ({ost_done_s, main_on_s})
    );

    assign clk_main = pll_sel ? clk_pll : clk_pri;

    clksw_gmux u_gmux (
        .clk_a   (clk_int),
        .clk_b   (clk_main),
        .rst     (rst),
        .sel_b   (want_main),
        .gate_a  (gate_int),
        .gate_b  (gate_main),
        .clk_out (sys_clk)
    );

    assign int_osc_en = ~pri_stable | wdt_en | fscm_en;

    p_int_alive_r10: assert property (@(posedge clk_int) disable iff (rst)
        gate_int |-> int_osc_en);
    p_stable_on_main_r6: assert property (@(posedge clk_int) disable iff (rst)
        pri_stable |-> (main_on_s && !gate_int));
endmodule

// File: tb/clksw_ctl_test.sv
`timescale 1ns/1ps
module clksw_ctl_test;
    localparam int  OST   = 1024;
    localparam int  LOCK  = 40;
    localparam int  MINW  = (OST * 4) / 5 - 2;
    localparam int  SLACK = 30;

    logic clk_int = 1'b0, clk_pri = 1'b0, clk_pll = 1'b0;
    logic rst = 1'b1, cfg_wr = 1'b0, cfg_idle = 1'b0, pll_use = 1'b0;
    logic wdt_en = 1'b0, fscm_en = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic [1:0] sel_q;
    logic idle_q, pri_en, pll_en, pri_stable, int_osc_en, sys_clk;

    always #2.5 clk_int = ~clk_int;
    always #2.0 clk_pri = ~clk_pri;
    always #1.0 clk_pll = ~clk_pll;

    clksw_ctl #(.OST_CYCLES(OST), .PLL_LOCK_CYCLES(LOCK)) uut (
        .clk_int(clk_int), .clk_pri(clk_pri), .clk_pll(clk_pll), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idle(cfg_idle), .pll_use(pll_use),
        .wdt_en(wdt_en), .fscm_en(fscm_en), .sel_q(sel_q), .idle_q(idle_q),
        .pri_en(pri_en), .pll_en(pll_en), .pri_stable(pri_stable),
        .int_osc_en(int_osc_en), .sys_clk(sys_clk)
    );

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // sys_clk timing: period between rising edges and width of every phase
    real last_rise = -1.0, last_period = 0.0, last_chg = 0.0;
    always @(posedge sys_clk) begin
        if (last_rise >= 0.0) last_period = $realtime - last_rise;
        last_rise = $realtime;
    end
    always @(sys_clk) begin
        if (!rst && last_chg > 20.0) begin
            vectors++;
            if ($realtime - last_chg < 0.99) begin
                miscompares++;
                $display("FAIL R11 at %0t: actual phase %0d ps expected >= 1000 ps",
                         $time, int'(($realtime - last_chg) * 1000.0));
            end
        end
        last_chg = $realtime;
    end

    // behavioural reference model, compared on every internal clock
    int m_sel = 3, m_idle = 0, m_pri = 0, m_pll = 0, m_abort = 0;
    int t_up = 0, t_drain = 100, t_rst = 0;
    always @(posedge clk_int) begin : model
        logic w, idl, pu;
        logic [1:0] s;
        int lo, hi;
        w = cfg_wr; s = cfg_sel; idl = cfg_idle; pu = pll_use;
        #1;
        if (rst) begin
            m_sel = 3; m_idle = 0; m_pri = 0; m_pll = 0; m_abort = 0;
            t_up = 0; t_drain = 100; t_rst = 0;
        end else begin
            lo = MINW + (m_pll != 0 ? LOCK : 0);
            if (w) begin
                m_sel = int'(s); m_idle = int'(idl);
                if (s == 2'b11) begin
                    if (m_pri != 0) begin
                        m_abort = (t_up < lo) ? 1 : 0;
                        m_pri = 0; t_drain = 0;
                    end
                end else if (m_pri == 0) begin
                    m_pri = 1; t_up = 0; m_pll = int'(pu);
                end
            end
            lo = MINW + (m_pll != 0 ? LOCK : 0);
            hi = lo + SLACK;
            if (t_rst < 3) begin
                chk("R1 sel", int'(sel_q), 3);
                chk("R1 pri_en", int'(pri_en), 0);
                chk("R1 pll_en", int'(pll_en), 0);
                chk("R1 stable", int'(pri_stable), 0);
            end
            chk(w ? "R2 sel load" : "R9 sel held", int'(sel_q), m_sel);
            chk(w ? "R2 idle load" : "R9 idle held", int'(idle_q), m_idle);
            chk("R10 keepalive", int'(int_osc_en),
                (pri_stable == 1'b0 || wdt_en || fscm_en) ? 1 : 0);
            if (m_pri != 0) begin
                chk("R3 pri_en", int'(pri_en), 1);
                chk("R3 pll_en", int'(pll_en), m_pll);
                if (t_up < lo) chk(m_pll != 0 ? "R5 lock wait" : "R4 ost wait", int'(pri_stable), 0);
                if (t_up > hi) chk("R6 stable", int'(pri_stable), 1);
                if (t_up > 10 && t_up < lo) chk("R3 sys period", int'(last_period * 100.0), 500);
                if (t_up > hi + 5)
                    chk("R6 sys period", int'(last_period * 100.0), m_pll != 0 ? 200 : 400);
                t_up++;
            end else begin
                chk(m_abort != 0 ? "R8 stable" : "R7 stable", int'(pri_stable), 0);
                if (t_drain > 12) begin
                    chk(m_abort != 0 ? "R8 pri_en" : "R7 pri_en", int'(pri_en), 0);
                    chk("R7 pll_en", int'(pll_en), 0);
                end
                if (t_drain > 20)
                    chk(t_rst < 30 ? "R1 sys period" : "R7 sys period",
                        int'(last_period * 100.0), 500);
                if (t_drain < 1000) t_drain++;
            end
            if (t_rst < 1000) t_rst++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_int);
    endtask

    task automatic wr(input logic [1:0] s, input logic i);
        @(negedge clk_int);
        cfg_wr = 1'b1; cfg_sel = s; cfg_idle = i;
        @(negedge clk_int);
        cfg_wr = 1'b0; cfg_sel = ~s; cfg_idle = ~i;
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        cyc(10);
        rst = 1'b0;
        cyc(40);
        pll_use = 1'b0; wr(2'b00, 1'b1); cyc(920);          // primary, no PLL
        wr(2'b11, 1'b0); cyc(50);                            // back to internal
        wdt_en = 1'b1; pll_use = 1'b1; wr(2'b01, 1'b0);      // primary via PLL
        cyc(960);
        wdt_en = 1'b0; fscm_en = 1'b1; cyc(20);
        wr(2'b11, 1'b1); cyc(50);
        fscm_en = 1'b0; pll_use = 1'b0; wr(2'b10, 1'b0);     // abort in start-up
        cyc(300); wr(2'b11, 1'b0); cyc(60);
        pll_use = 1'b1; wr(2'b00, 1'b1);                     // abort in lock
        cyc(832); wr(2'b11, 1'b1); cyc(60);
        pll_use = 1'b0; wr(2'b00, 1'b0); cyc(920);
        pll_use = 1'b1; wr(2'b10, 1'b1); cyc(30);            // reselect while primary
        wr(2'b11, 1'b0); cyc(50);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule